// File: doc/BRIEF.md
# Memory-Reference Address and Execute Unit

This unit carries out the six memory-reference operations of a 12-bit processor whose addresses are 15 bits wide: a 3-bit field on top of a 12-bit in-field address. It is given one instruction word, the current program counter, the accumulator and the link. It builds the effective address from a 7-bit offset, a page-select bit and the program counter's field. When the instruction asks for indirection, it fetches one pointer word from memory first. It then runs the operation through a single-outstanding request/response memory port and returns the new accumulator, the new link and the next program counter.

Opcodes 6 and 7 belong to other units. When one of them is offered, the unit flags it in the same cycle and stays idle. A sequencer steps through pointer fetch, operand load and store, with one memory request in each step. The result is presented for a single cycle through a `done` pulse.

Top module: `mref_exec_unit`

## Requirements
- R1: The direct address is {pc_in[14:12], page, instr[6:0]}. The page is pc_in[11:7] when instr[7] is 1 and zero when instr[7] is 0.
- R2: When instr[8] is 1, the unit first reads the word at the direct address. The final address is {pc_in[14:12], that word}. When instr[8] is 0, no pointer read takes place.
- R3: Opcode instr[11:9]=0 reads the word at the final address and returns acc_in AND that word. The link is unchanged.
- R4: Opcode 1 reads the word and returns the low 12 bits of acc_in plus the word. The link is inverted when the sum carries out of bit 11.
- R5: Opcode 2 reads the word and writes (word+1) mod 4096 back to the same address. When that value is 0, next_pc is the field with pc_in[11:0]+2 (mod 4096). Otherwise it follows R11.
- R6: Opcode 3 writes acc_in to the final address and returns an accumulator of 0.
- R7: Opcode 4 writes (pc_in[11:0]+1) mod 4096 to the final address. next_pc is the field with (final[11:0]+1) mod 4096.
- R8: Opcode 5 sets next_pc to the final address. A direct jump makes no memory access.
- R9: When start is high and instr[11:9] is 6 or 7, not_mine is high in that cycle. The unit makes no memory access and stays idle.
- R10: Accesses take place one at a time. mem_req, mem_we, mem_addr and mem_wdata stay stable until the cycle in which mem_ack is high, and read data is taken in that cycle. Each access in R2 to R8 occurs once, in the order pointer, load, store.
- R11: done is a one-cycle pulse. It is due in the cycle after the edge that accepts the last acknowledge, or after the start edge when there is no access. acc_out, link_out and next_pc are valid while done is high. Unless R5, R7 or R8 applies, next_pc is the field with (pc_in[11:0]+1) mod 4096, and the field never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Offer an instruction (taken when idle) |
| instr | input | 12 | Instruction word |
| pc_in | input | 15 | Program counter of the instruction (field and address) |
| acc_in | input | 12 | Accumulator before the instruction |
| link_in | input | 1 | Link before the instruction |
| not_mine | output | 1 | Offered opcode is not handled by this unit |
| busy | output | 1 | An instruction is in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 15 | Memory address |
| mem_wdata | output | 12 | Write data |
| mem_ack | input | 1 | Memory acknowledge; read data valid |
| mem_rdata | input | 12 | Read data |
| done | output | 1 | Results valid (one cycle) |
| acc_out | output | 12 | New accumulator |
| link_out | output | 1 | New link |
| next_pc | output | 15 | Next program counter |

## Verification
A direct jump finishes one cycle after its start edge. Every other instruction finishes one cycle after the edge that takes its last acknowledge. The memory model acknowledges after a random wait of zero to two cycles. For this reason the bench samples on falling edges and waits for done, with a bounded count, instead of counting cycles blindly. It checks the results in the first sample in which done is high. It checks that done is low again in the very next sample. Foreign opcodes are checked for not_mine while start is still held, and for idleness a few cycles later.

// File: rtl/mref_pkg.sv
package mref_pkg;
    localparam int WORD_W  = 12;
    localparam int FIELD_W = 3;
    localparam int OFFS_W  = 7;
    localparam int OPC_W   = 3;
    localparam int ADDR_W  = WORD_W + FIELD_W;
    localparam int PAGE_W  = WORD_W - OFFS_W;
    localparam int IND_BIT  = WORD_W - OPC_W - 1;
    localparam int PAGE_BIT = WORD_W - OPC_W - 2;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IND,
        ST_OPL,
        ST_STO,
        ST_FIN
    } st_e;

    typedef struct packed {
        word_t acc;
        logic  link;
        word_t mem;
        logic  zero;
    } alu_res_t;

    // Advance the in-field part of an address; the field is never touched.
    function automatic addr_t bump(addr_t a, word_t n);
        word_t low;
        low = a[WORD_W-1:0] + n;
        return {a[ADDR_W-1:WORD_W], low};
    endfunction

    function automatic logic handled(logic [OPC_W-1:0] opc);
        return opc <= OP_JMP;
    endfunction

    // Step that follows once the final address is known.
    function automatic st_e after_addr(op_e op);
        case (op)
            OP_AND, OP_TAD, OP_ISZ: return ST_OPL;
            OP_DCA, OP_JMS:         return ST_STO;
            default:                return ST_FIN;
        endcase
    endfunction
endpackage

// File: rtl/mref_addr_gen.sv
module mref_addr_gen
    import mref_pkg::*;
(
    input  addr_t pc,
    input  word_t instr,
    output addr_t direct
);
    logic [PAGE_W-1:0] page;

    always_comb begin
        page   = instr[PAGE_BIT] ? pc[WORD_W-1:OFFS_W] : {PAGE_W{1'b0}};
        direct = {pc[ADDR_W-1:WORD_W], page, instr[OFFS_W-1:0]};
    end
endmodule

// File: rtl/mref_alu.sv
module mref_alu
    import mref_pkg::*;
(
    input  op_e      op,
    input  word_t    acc,
    input  logic     link,
    input  word_t    mdata,
    output alu_res_t res
);
    logic [WORD_W:0] sum;

    always_comb begin
        sum      = {1'b0, acc} + {1'b0, mdata};
        res.acc  = acc;
        res.link = link;
        res.mem  = mdata + word_t'(1);
        res.zero = (res.mem == '0);
        case (op)
            OP_AND: res.acc = acc & mdata;
            OP_TAD: begin
                res.acc  = sum[WORD_W-1:0];
                res.link = link ^ sum[WORD_W];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mref_exec_unit.sv
module mref_exec_unit
    import mref_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [11:0] instr,
    input  logic [14:0] pc_in,
    input  logic [11:0] acc_in,
    input  logic        link_in,
    output logic        not_mine,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [14:0] mem_addr,
    output logic [11:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [11:0] mem_rdata,
    output logic        done,
    output logic [11:0] acc_out,
    output logic        link_out,
    output logic [14:0] next_pc
);
    st_e      st;
    op_e      op_r;
    addr_t    ea_r, npc_r, direct;
    word_t    acc_r, data_r;
    logic     link_r, skip_r;
    alu_res_t alu;
    logic [OPC_W-1:0] opc;

    assign opc = instr[WORD_W-1:WORD_W-OPC_W];

    mref_addr_gen u_addr (
        .pc     (pc_in),
        .instr  (instr),
        .direct (direct)
    );

    mref_alu u_alu (
        .op    (op_r),
        .acc   (acc_r),
        .link  (link_r),
        .mdata (mem_rdata),
        .res   (alu)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_r   <= OP_AND;
            ea_r   <= '0;
            npc_r  <= '0;
            acc_r  <= '0;
            data_r <= '0;
            link_r <= 1'b0;
            skip_r <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start && handled(opc)) begin
                    op_r   <= op_e'(opc);
                    acc_r  <= acc_in;
                    link_r <= link_in;
                    npc_r  <= bump(pc_in, word_t'(1));
                    skip_r <= 1'b0;
                    ea_r   <= direct;
                    st     <= instr[IND_BIT] ? ST_IND : after_addr(op_e'(opc));
                end
                ST_IND: if (mem_ack) begin
                    ea_r <= {ea_r[ADDR_W-1:WORD_W], mem_rdata};
                    st   <= after_addr(op_r);
                end
                ST_OPL: if (mem_ack) begin
                    acc_r  <= alu.acc;
                    link_r <= alu.link;
                    data_r <= alu.mem;
                    skip_r <= alu.zero;
                    st     <= (op_r == OP_ISZ) ? ST_STO : ST_FIN;
                end
                ST_STO: if (mem_ack) begin
                    if (op_r == OP_DCA) acc_r <= '0;
                    st <= ST_FIN;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (op_r)
            OP_ISZ:  mem_wdata = data_r;
            OP_DCA:  mem_wdata = acc_r;
            OP_JMS:  mem_wdata = npc_r[WORD_W-1:0];
            default: mem_wdata = '0;
        endcase
        case (op_r)
            OP_JMP:  next_pc = ea_r;
            OP_JMS:  next_pc = bump(ea_r, word_t'(1));
            OP_ISZ:  next_pc = skip_r ? bump(npc_r, word_t'(1)) : npc_r;
            default: next_pc = npc_r;
        endcase
    end

    assign mem_req  = (st == ST_IND) || (st == ST_OPL) || (st == ST_STO);
    assign mem_we   = (st == ST_STO);
    assign mem_addr = ea_r;
    assign done     = (st == ST_FIN);
    assign busy     = (st != ST_IDLE);
    assign not_mine = start && !handled(opc);
    assign acc_out  = acc_r;
    assign link_out = link_r;

    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    a_r10_write_is_request: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_foreign_stays_idle: assert property (@(posedge clk) disable iff (rst)
        start && not_mine && !busy |=> !busy && !mem_req);

    a_r6_deposit_clears: assert property (@(posedge clk) disable iff (rst)
        done && op_r == OP_DCA |-> acc_out == '0);

    a_r11_field_kept: assert property (@(posedge clk) disable iff (rst)
        done |-> next_pc[ADDR_W-1:WORD_W] == npc_r[ADDR_W-1:WORD_W]);
endmodule

// File: tb/tb_mref_exec_unit.sv
`timescale 1ns/1ps
module tb_mref_exec_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] instr = '0;
    logic [14:0] pc_in = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic        not_mine, busy, mem_req, mem_we, done, link_out;
    logic [14:0] mem_addr, next_pc;
    logic [11:0] mem_wdata, acc_out;
    logic        mem_ack = 1'b0;
    logic [11:0] mem_rdata = '0;

    always #2 clk = ~clk;

    mref_exec_unit dut (
        .clk(clk), .rst(rst), .start(start), .instr(instr), .pc_in(pc_in),
        .acc_in(acc_in), .link_in(link_in), .not_mine(not_mine), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .acc_out(acc_out), .link_out(link_out), .next_pc(next_pc)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    logic [11:0] mem [int];
    int salt = 0;
    int acc_n = 0;
    int wcnt = 0;
    int lat = 0;
    int          log_addr [8];
    logic        log_we   [8];
    logic [11:0] log_wd   [8];

    function automatic logic [11:0] rd(int a);
        if (mem.exists(a)) return mem[a];
        return 12'((a * 37 + salt) & 4095);
    endfunction

    // Memory model: acknowledges after 0..2 waiting cycles.
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_req && wcnt >= lat) begin
            mem_ack   = 1'b1;
            mem_rdata = rd(int'(mem_addr));
            if (acc_n < 8) begin
                log_addr[acc_n] = int'(mem_addr);
                log_we[acc_n]   = mem_we;
                log_wd[acc_n]   = mem_wdata;
            end
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            acc_n++;
            wcnt = 0;
            lat = int'($urandom % 3);
        end else begin
            mem_ack = 1'b0;
            if (mem_req) wcnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
        end
    endtask

    task automatic run(logic [11:0] ins, logic [14:0] pc, logic [11:0] a, logic l);
        int op;
        logic [2:0]  fld;
        logic [14:0] da, ea, e_pc;
        logic [11:0] m, e_acc, lowp;
        logic [12:0] sum;
        logic        e_link;
        int          e_n;
        int          e_addr [4];
        logic        e_we   [4];
        logic [11:0] e_wd   [4];
        string       tag;
        int          cyc;
        op  = int'(ins[11:9]);
        fld = pc[14:12];
        da  = {fld, (ins[7] ? pc[11:7] : 5'd0), ins[6:0]};
        e_n = 0;
        if (ins[8]) begin
            ea = {fld, rd(int'(da))};
            e_addr[e_n] = int'(da); e_we[e_n] = 0; e_wd[e_n] = '0; e_n++;
        end else begin
            ea = da;
        end
        m = rd(int'(ea));
        e_acc = a; e_link = l;
        lowp = pc[11:0] + 12'd1;
        e_pc = {fld, lowp};
        tag = "R8";
        case (op)
            0: begin
                tag = "R3";
                e_addr[e_n] = int'(ea); e_we[e_n] = 0; e_wd[e_n] = '0; e_n++;
                e_acc = a & m;
            end
            1: begin
                tag = "R4";
                e_addr[e_n] = int'(ea); e_we[e_n] = 0; e_wd[e_n] = '0; e_n++;
                sum = {1'b0, a} + {1'b0, m};
                e_acc = sum[11:0];
                e_link = l ^ sum[12];
            end
            2: begin
                tag = "R5";
                e_addr[e_n] = int'(ea); e_we[e_n] = 0; e_wd[e_n] = '0; e_n++;
                e_addr[e_n] = int'(ea); e_we[e_n] = 1; e_wd[e_n] = m + 12'd1; e_n++;
                if (m == 12'o7777) e_pc = {fld, pc[11:0] + 12'd2};
            end
            3: begin
                tag = "R6";
                e_addr[e_n] = int'(ea); e_we[e_n] = 1; e_wd[e_n] = a; e_n++;
                e_acc = '0;
            end
            4: begin
                tag = "R7";
                e_addr[e_n] = int'(ea); e_we[e_n] = 1; e_wd[e_n] = lowp; e_n++;
                e_pc = {fld, ea[11:0] + 12'd1};
            end
            default: e_pc = ea;
        endcase

        acc_n = 0;
        @(negedge clk);
        start = 1'b1; instr = ins; pc_in = pc; acc_in = a; link_in = l;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            chk({tag, " R11 done never rose"}, 0, 1);
        end else begin
            chk({tag, " acc_out"}, int'(acc_out), int'(e_acc));
            chk({tag, " link_out"}, int'(link_out), int'(e_link));
            chk({tag, " R11 next_pc"}, int'(next_pc), int'(e_pc));
            chk({tag, " R10 access count"}, acc_n, e_n);
            for (int i = 0; i < e_n && i < acc_n; i++) begin
                chk({tag, " R1 R2 access address"}, log_addr[i], e_addr[i]);
                chk({tag, " R10 access direction"}, int'(log_we[i]), int'(e_we[i]));
                if (e_we[i]) chk({tag, " store data"}, int'(log_wd[i]), int'(e_wd[i]));
            end
            @(negedge clk);
            chk("R11 done single cycle", int'(done), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset done", int'(done), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R10 reset mem_req", int'(mem_req), 0);

        // R9: foreign opcodes 6 and 7
        for (int k = 6; k < 8; k++) begin
            acc_n = 0;
            start = 1'b1; instr = {3'(k), 9'o123};
            #0.1;
            chk("R9 not_mine raised", int'(not_mine), 1);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk("R9 stays idle", int'(busy), 0);
            chk("R9 no access", acc_n, 0);
        end

        // R5: skip on wrap, PC wraps inside field
        mem[15'o17776] = 12'o7777;
        run({3'd2, 1'b0, 1'b1, 7'o176}, 15'o17776, 12'o1, 1'b0);
        // R4: carry toggles link
        mem[15'o20005] = 12'o0001;
        run({3'd1, 1'b0, 1'b0, 7'o005}, 15'o23456, 12'o7777, 1'b1);
        // R7 with R2: call through pointer to the last word of the field
        mem[15'o30010] = 12'o7777;
        run({3'd4, 1'b1, 1'b0, 7'o010}, 15'o34567, 12'o0, 1'b0);
        // R8: direct jump on page zero from a nonzero page
        run({3'd5, 1'b0, 1'b0, 7'o077}, 15'o45432, 12'o0, 1'b0);
        // R6 with R2: indirect deposit
        run({3'd3, 1'b1, 1'b1, 7'o011}, 15'o51234, 12'o4321, 1'b0);
        // R3: current-page AND
        run({3'd0, 1'b0, 1'b1, 7'o033}, 15'o60777, 12'o7070, 1'b1);

        for (int it = 0; it < 300; it++) begin
            logic [11:0] ins;
            if (it % 16 == 0) mem.delete();
            salt = int'($urandom % 4096);
            ins = 12'($urandom);
            ins[11:9] = 3'($urandom % 6);
            if ($urandom % 8 == 0) mem[int'({3'd0, 12'd0})] = 12'o7777;
            run(ins, 15'($urandom), 12'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule